// File: doc/BRIEF.md
# Interrupt Message Queue Writer

This block collects short status notices from several data-channel controllers and from the command logic, packs each into a single 32-bit record, and writes the records one after another into a host-memory ring set aside as channel 0. Because every device-to-host report travels this way, the host never needs to read a device status register: it reads the ring and is woken by an interrupt pulse.

Each channel controller raises a request with an opcode, a buffer index and a byte count. The block grants at most one request per cycle and drives a simple memory write port one cycle later. A quiesce acknowledge, which carries the length of the configuration description table, has priority over channel traffic. The host returns ring space by writing a credit count, and clears the pending interrupt by writing an acknowledge.

Two state machines do the work. The ring controller has states RING_OPEN and RING_FULL. It moves OPEN->FULL when the fill count after the cycle's write and credit reaches the ring depth, and FULL->OPEN when a credit lowers the fill. While it is in FULL, no request is granted and requesters stall. The interrupt controller has states IRQ_IDLE, IRQ_RAISE and IRQ_WAIT. It moves IDLE->RAISE when a record is written, RAISE->WAIT unconditionally after the one-cycle pulse, and WAIT->IDLE on a host acknowledge.

Top module: `msgq_writer`

## Requirements
- R1: Each record is one 32-bit word with the opcode in bits [31:28], the channel number in [27:20], the buffer index in [19:12] and the byte count in [11:0]. Opcodes are 1 for buffer release, 2 for nonempty and 3 for quiesce acknowledge.
- R2: A record from requester i carries channel number i+1. Channel 0 is used only by quiesce-acknowledge records.
- R3: A quiesce-acknowledge record has opcode 3, channel 0, buffer index 0 and the table length in the byte-count field. When it competes with channel requests, it is granted first.
- R4: Simultaneous channel requests are granted round-robin. After requester k is granted, the search starts at requester k+1 (wrapping), and after reset it starts at requester 0.
- R5: At most one request is granted per cycle. The record for a grant is written in the following cycle, with mem_wr_en high for exactly that cycle.
- R6: Write addresses start at 0 after reset and step by one per record, wrapping modulo the ring depth 2^AW.
- R7: When 2^AW records are outstanding without credit, no request is granted, and the waiting request stays pending; no record is dropped.
- R8: A credit write of n frees n ring entries (at most the number outstanding), and a stalled request is then granted and written.
- R9: When no interrupt is pending, irq_pulse is high for one cycle, in the cycle after the record write.
- R10: While an interrupt is pending, further records raise no pulse. After irq_ack, the next record raises one again.
- R11: After reset, mem_wr_en, irq_pulse and the grants are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NREQ | Per-requester message request, held until granted |
| req_op | input | 4*NREQ | Per-requester opcode |
| req_bidx | input | 8*NREQ | Per-requester buffer index |
| req_bcnt | input | 12*NREQ | Per-requester byte count |
| req_grant | output | NREQ | One-hot grant, combinational |
| qack_valid | input | 1 | Quiesce-acknowledge request |
| qack_len | input | 12 | Configuration table length for the acknowledge |
| qack_grant | output | 1 | Grant for the quiesce acknowledge |
| credit_we | input | 1 | Host credit write strobe |
| credit_num | input | AW+1 | Number of ring entries returned |
| irq_ack | input | 1 | Host interrupt acknowledge strobe |
| mem_wr_en | output | 1 | Ring write enable |
| mem_wr_addr | output | AW | Ring write address |
| mem_wr_data | output | 32 | Record written |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
A lone request checks the record layout, the channel numbering and the grant-to-write and write-to-interrupt latencies. Patterns with all requesters at once, and then a pair, check that the round-robin pointer moves past the last winner rather than favouring low indices. A quiesce acknowledge raised with a channel request tells fixed priority apart from rotation. Filling the ring and holding one more request shows stalling as opposed to dropping, and that a credit releases the stall. Writes made before and after irq_ack show the coalescing of interrupts.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

    typedef enum logic [3:0] {
        OP_NONE     = 4'd0,
        OP_BUFREL   = 4'd1,
        OP_NONEMPTY = 4'd2,
        OP_QACK     = 4'd3
    } msg_op_t;

    typedef struct packed {
        logic [3:0]  op;
        logic [7:0]  chan;
        logic [7:0]  bidx;
        logic [11:0] bcnt;
    } msg_t;

endpackage

// File: rtl/msgq_rr_arb.sv
module msgq_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] gidx
);
    localparam int PW = $clog2(N);

    logic [PW-1:0] ptr;
    logic          found;
    int            c;

    always_comb begin
        grant = '0;
        gidx  = '0;
        found = 1'b0;
        c     = 0;
        for (int k = 0; k < N; k++) begin
            c = (int'(ptr) + k) % N;
            if (en && !found && req[c]) begin
                found    = 1'b1;
                grant[c] = 1'b1;
                gidx     = PW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (found) begin
            ptr <= (gidx == PW'(N - 1)) ? '0 : gidx + 1'b1;
        end
    end

    // R5: never more than one winner
    p_onehot_grant_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R4: only requesting inputs win
    p_grant_requested_r4: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

endmodule

// File: rtl/msgq_ring_ctrl.sv
module msgq_ring_ctrl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          credit_we,
    input  logic [AW:0]   credit_num,
    output logic          space_ok,
    output logic [AW-1:0] wr_ptr
);
    localparam logic [AW:0] DEPTH_V = (AW + 1)'(1) << AW;

    typedef enum logic {RING_OPEN, RING_FULL} ring_st_t;

    ring_st_t    st, st_nx;
    logic [AW:0] fill, fill_nx, cred_eff;

    always_comb begin
        cred_eff = '0;
        if (credit_we) begin
            cred_eff = (credit_num > fill) ? fill : credit_num;
        end
        fill_nx = fill + {{AW{1'b0}}, take} - cred_eff;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RING_OPEN: if (fill_nx == DEPTH_V) st_nx = RING_FULL;
            RING_FULL: if (fill_nx != DEPTH_V) st_nx = RING_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RING_OPEN;
            fill   <= '0;
            wr_ptr <= '0;
        end else begin
            st   <= st_nx;
            fill <= fill_nx;
            if (take) wr_ptr <= wr_ptr + 1'b1;
        end
    end

    always_comb begin
        unique case (st)
            RING_OPEN: space_ok = 1'b1;
            RING_FULL: space_ok = 1'b0;
        endcase
    end

    // R7: the ring never holds more than its depth
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        fill <= DEPTH_V);
    // R7: no write is taken while full
    p_no_take_full_r7: assert property (@(posedge clk) disable iff (rst)
        (st == RING_FULL) |-> !take);

endmodule

// File: rtl/msgq_irq_ctrl.sv
module msgq_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic wr_seen,
    input  logic ack,
    output logic irq_pulse
);
    typedef enum logic [1:0] {IRQ_IDLE, IRQ_RAISE, IRQ_WAIT} irq_st_t;

    irq_st_t st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            IRQ_IDLE:  if (wr_seen) st_nx = IRQ_RAISE;
            IRQ_RAISE: st_nx = IRQ_WAIT;
            IRQ_WAIT:  if (ack) st_nx = IRQ_IDLE;
            default:   st_nx = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= IRQ_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        unique case (st)
            IRQ_RAISE: irq_pulse = 1'b1;
            default:   irq_pulse = 1'b0;
        endcase
    end

    // R9: a pulse always follows a record write
    p_pulse_after_write_r9: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(wr_seen));
    // R10: pulses never run back to back
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);

endmodule

// File: rtl/msgq_writer.sv
module msgq_writer #(
    parameter int NREQ = 4,
    parameter int AW   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NREQ-1:0]   req_valid,
    input  logic [4*NREQ-1:0] req_op,
    input  logic [8*NREQ-1:0] req_bidx,
    input  logic [12*NREQ-1:0] req_bcnt,
    output logic [NREQ-1:0]   req_grant,
    input  logic              qack_valid,
    input  logic [11:0]       qack_len,
    output logic              qack_grant,
    input  logic              credit_we,
    input  logic [AW:0]       credit_num,
    input  logic              irq_ack,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              irq_pulse
);
    import msgq_pkg::*;

    localparam int PW = $clog2(NREQ);

    logic          space_ok;
    logic [AW-1:0] wr_ptr;
    logic [PW-1:0] gidx;
    logic          take;
    msg_t          word;

    assign qack_grant = qack_valid & space_ok;

    msgq_rr_arb #(.N(NREQ)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .en    (space_ok & ~qack_valid),
        .req   (req_valid),
        .grant (req_grant),
        .gidx  (gidx)
    );

    assign take = qack_grant | (|req_grant);

    msgq_ring_ctrl #(.AW(AW)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .credit_we  (credit_we),
        .credit_num (credit_num),
        .space_ok   (space_ok),
        .wr_ptr     (wr_ptr)
    );

    always_comb begin
        if (qack_grant) begin
            word.op   = OP_QACK;
            word.chan = 8'd0;
            word.bidx = 8'd0;
            word.bcnt = qack_len;
        end else begin
            word.op   = req_op[4*gidx +: 4];
            word.chan = 8'(gidx) + 8'd1;
            word.bidx = req_bidx[8*gidx +: 8];
            word.bcnt = req_bcnt[12*gidx +: 12];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            mem_wr_en   <= take;
            mem_wr_addr <= wr_ptr;
            mem_wr_data <= word;
        end
    end

    msgq_irq_ctrl u_irq (
        .clk       (clk),
        .rst       (rst),
        .wr_seen   (mem_wr_en),
        .ack       (irq_ack),
        .irq_pulse (irq_pulse)
    );

    // R6: back-to-back records use consecutive addresses
    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && $past(mem_wr_en)) |-> (mem_wr_addr == $past(mem_wr_addr) + 1'b1));
    // R2: channel 0 records are only quiesce acknowledges
    p_ch0_only_qack_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wr_data[27:20] == 8'd0) |-> (mem_wr_data[31:28] == OP_QACK));
    // R5: a grant is followed by a write
    p_write_after_grant_r5: assert property (@(posedge clk) disable iff (rst)
        take |=> mem_wr_en);

endmodule

// File: tb/sim_msgq_writer.sv
`timescale 1ns/1ps
module sim_msgq_writer;
    localparam int NREQ = 3;
    localparam int AW   = 2;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NREQ-1:0]   req_valid = '0;
    logic [4*NREQ-1:0] req_op = '0;
    logic [8*NREQ-1:0] req_bidx = '0;
    logic [12*NREQ-1:0] req_bcnt = '0;
    logic [NREQ-1:0]   req_grant;
    logic              qack_valid = 1'b0;
    logic [11:0]       qack_len = '0;
    logic              qack_grant;
    logic              credit_we = 1'b0;
    logic [AW:0]       credit_num = '0;
    logic              irq_ack = 1'b0;
    logic              mem_wr_en;
    logic [AW-1:0]     mem_wr_addr;
    logic [31:0]       mem_wr_data;
    logic              irq_pulse;

    msgq_writer #(.NREQ(NREQ), .AW(AW)) u0 (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    int cyc = 0;
    int wr_cnt = 0, irq_cnt = 0, last_wr_cyc = -1, last_irq_cyc = -1, last_gnt_cyc = -1;
    int pushed = 0, credited = 0;
    logic [31:0]   exp_data[$];
    logic [AW-1:0] exp_addr[$];
    logic [AW-1:0] next_addr = '0;
    int order[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [7:0] ch,
                                       input logic [7:0] b, input logic [11:0] n);
        return {op, ch, b, n};
    endfunction

    task automatic push(input logic [31:0] w);
        exp_data.push_back(w);
        exp_addr.push_back(next_addr);
        next_addr = next_addr + 1'b1;
        pushed++;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && mem_wr_en) begin
            wr_cnt++;
            last_wr_cyc = cyc;
            if (exp_data.size() == 0) begin
                chk(0, "R5 unexpected write", mem_wr_data, 0);
            end else begin
                logic [31:0]   ed;
                logic [AW-1:0] ea;
                ed = exp_data.pop_front();
                ea = exp_addr.pop_front();
                chk(mem_wr_data == ed, "R1/R2/R3 record", mem_wr_data, ed);
                chk(mem_wr_addr == ea, "R6 address", mem_wr_addr, ea);
            end
        end
        if (!rst && irq_pulse) begin
            irq_cnt++;
            last_irq_cyc = cyc;
        end
    end

    task automatic send(input int i, input logic [3:0] op, input logic [7:0] b, input logic [11:0] n);
        @(negedge clk);
        req_valid[i] = 1'b1;
        req_op[i*4 +: 4] = op;
        req_bidx[i*8 +: 8] = b;
        req_bcnt[i*12 +: 12] = n;
        #1;
        while (!req_grant[i]) begin
            @(negedge clk);
            #1;
        end
        last_gnt_cyc = cyc;
        push(mk(op, 8'(i + 1), b, n));
        order.push_back(i);
        @(negedge clk);
        req_valid[i] = 1'b0;
    endtask

    task automatic send_qack(input logic [11:0] len);
        @(negedge clk);
        qack_valid = 1'b1;
        qack_len = len;
        #1;
        while (!qack_grant) begin
            @(negedge clk);
            #1;
        end
        push(mk(4'd3, 8'd0, 8'd0, len));
        order.push_back(99);
        @(negedge clk);
        qack_valid = 1'b0;
    endtask

    task automatic credit(input int n);
        @(negedge clk);
        credit_we = 1'b1;
        credit_num = (AW + 1)'(n);
        @(negedge clk);
        credit_we = 1'b0;
        credited += n;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        credit(pushed - credited);
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(mem_wr_en == 0, "R11 mem_wr_en after reset", mem_wr_en, 0);
        chk(irq_pulse == 0, "R11 irq_pulse after reset", irq_pulse, 0);
        chk(req_grant == 0 && qack_grant == 0, "R11 grants after reset", req_grant, 0);

        // single buffer release from requester 1 -> channel 2
        send(1, 4'd1, 8'd5, 12'h123);
        repeat (3) @(negedge clk);
        chk(last_wr_cyc == last_gnt_cyc + 1, "R5 write one cycle after grant", last_wr_cyc, last_gnt_cyc + 1);
        chk(irq_cnt == 1, "R9 one interrupt pulse", irq_cnt, 1);
        chk(last_irq_cyc == last_wr_cyc + 1, "R9 pulse timing", last_irq_cyc, last_wr_cyc + 1);
        drain();

        // all three at once: pointer after requester 1 -> 2,0,1 (no ack: coalesced)
        order.delete();
        fork
            send(0, 4'd2, 8'd0, 12'd0);
            send(1, 4'd1, 8'd7, 12'hfff);
            send(2, 4'd1, 8'hff, 12'd4);
        join
        repeat (3) @(negedge clk);
        chk(order.size() == 3 && order[0] == 2 && order[1] == 0 && order[2] == 1,
            "R4 rotation order 2,0,1", order.size() == 3 ? order[0]*100 + order[1]*10 + order[2] : -1, 201);
        chk(irq_cnt == 1, "R10 no pulse while pending", irq_cnt, 1);
        drain();

        ack();
        order.delete();
        fork
            send(0, 4'd1, 8'd1, 12'd10);
            send(2, 4'd1, 8'd2, 12'd20);
        join
        repeat (3) @(negedge clk);
        chk(order.size() == 2 && order[0] == 2 && order[1] == 0,
            "R4 rotation order 2,0", order.size() == 2 ? order[0]*10 + order[1] : -1, 20);
        chk(irq_cnt == 2, "R10 pulse again after ack", irq_cnt, 2);
        drain();

        // quiesce acknowledge beats a channel request
        order.delete();
        fork
            send(1, 4'd2, 8'd0, 12'd0);
            send_qack(12'h2a0);
        join
        repeat (3) @(negedge clk);
        chk(order.size() == 2 && order[0] == 99, "R3 quiesce ack first", order.size() == 2 ? order[0] : -1, 99);
        drain();

        // fill the ring, then stall one request
        for (int k = 0; k < DEPTH; k++) send(k % NREQ, 4'd1, 8'(k), 12'(k + 1));
        repeat (2) @(negedge clk);
        req_valid[0] = 1'b1;
        req_op[3:0] = 4'd1;
        req_bidx[7:0] = 8'h3c;
        req_bcnt[11:0] = 12'h0ab;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                #1;
                if (req_grant != 0) seen++;
            end
            chk(seen == 0, "R7 no grant while full", seen, 0);
            chk(wr_cnt == pushed, "R7 no extra write while full", wr_cnt, pushed);
        end
        credit(1);
        begin
            int waitc;
            waitc = 0;
            #1;
            while (!req_grant[0] && waitc < 10) begin
                @(negedge clk);
                #1;
                waitc++;
            end
            chk(req_grant[0] == 1'b1, "R8 stalled request served after credit", req_grant[0], 1);
            if (req_grant[0]) push(mk(4'd1, 8'd1, 8'h3c, 12'h0ab));
        end
        @(negedge clk);
        req_valid[0] = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_data.size() == 0, "R7 every record delivered", exp_data.size(), 0);
        chk(wr_cnt == pushed, "R8 write count", wr_cnt, pushed);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule